// File: doc/BRIEF.md
# Switch State Register Peripheral

This peripheral presents the state of a single named switch to a processor through a small 32-bit register bus. It occupies a 4 KB address window and drives one level-sensitive interrupt. A 32-bit state value can be updated from the switch side at any time. Each update stores the value, marks a change as pending, and raises the interrupt if software has enabled it. Software acknowledges a change by reading the interrupt status register. That read clears the pending change only when the change is both pending and enabled.

The block is built in one of two variants: input-only or output-capable. In the output-capable variant, software may write the state register. The block forwards the written value to the switch side over a valid/ready request. It then waits for the resulting state and holds the bus stalled until that state comes back. The new state counts as a change only if it differs from the stored value.

The block also holds a constant name string. Software reads the name's length from a register. Writing a memory address to the pointer register makes a copy engine write the name bytes, one per transfer, through a byte-wide memory write port. Any invalid access completes at once with read data 0, pulses an error output and sets a sticky error flag.

Top module: `switch_periph`

## Requirements
- R1: After reset, the stored state is 0, no change is pending, the interrupt enable is 0, `irq` is low and `err_flag` is low.
- R2: A read of offset 0x00 returns the number of bytes in the name, with no terminator counted (6 for the default name).
- R3: A read of offset 0x08 returns 1 in bit 0 when the block is output-capable and 0 when it is input-only. All other bits read 0.
- R4: A write of address A to offset 0x04 writes name byte i (first character at i = 0) to memory address A+i for every byte, in order. Each byte is held stable on the port until `mem_wr_ready` accepts it.
- R5: A cycle with `sw_upd_valid` high stores `sw_upd_state` as the new state (read at offset 0x0C) and sets the pending flag. From the next cycle, `irq` is high if the enable is 1.
- R6: A read of offset 0x10 returns 1 and clears both the pending flag and `irq` only when a change is pending and the enable is 1. Otherwise it returns 0 and leaves the pending flag as it was.
- R7: A write to offset 0x14 keeps only bit 0 of the data as the enable. While a change is pending, `irq` follows the enable from the cycle after the write.
- R8: On an output-capable block, a write to offset 0x0C sends the data on `out_req_data` and keeps `bus_ready` low until `out_rsp_valid` returns the resulting state. That state is stored and marked pending only if it differs from the current state.
- R9: A write to offset 0x0C on an input-only block is an error. So is any access to an unmapped or misaligned offset, and any access in the wrong direction to a mapped register. An error completes in one cycle with `bus_err` high and read data 0, and sets `err_flag` until reset.
- R10: If a switch-side update and a status-clearing read of offset 0x10 complete in the same cycle, the update wins: the new state is stored, the pending flag stays set, and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_err | output | 1 | Access is invalid, valid with `bus_ready` |
| err_flag | output | 1 | Sticky error flag |
| irq | output | 1 | Level interrupt |
| sw_upd_valid | input | 1 | Switch side reports a new state |
| sw_upd_state | input | 32 | New state from the switch side |
| out_req_valid | output | 1 | State request to the switch side is valid |
| out_req_data | output | 32 | Requested state |
| out_req_ready | input | 1 | Switch side accepts the request |
| out_rsp_valid | input | 1 | Resulting state is returned |
| out_rsp_state | input | 32 | Resulting state |
| mem_wr_valid | output | 1 | Name byte write is valid |
| mem_wr_addr | output | 32 | Name byte write address |
| mem_wr_data | output | 8 | Name byte |
| mem_wr_ready | input | 1 | Memory accepts the byte |

## Verification
The bench first reads the status while a change is pending but the interrupt is disabled, and then enables the interrupt. A design that cleared the pending flag on every status read would lose that change, and the later enable would not raise `irq`. The bench writes the enable with only bit 1 set, which catches a design that tests the whole word. It also writes the state register with a value the switch side echoes back unchanged, which catches a design that flags every output write as a change. The bench then lands a switch-side update in the same cycle as a clearing read. A design that gave the read priority would drop the interrupt and lose the new change. The name copy runs against a memory that accepts only every other cycle, so an engine that advanced without the handshake would skip or repeat bytes.

// File: rtl/sp_pkg.sv
// Package: shared encodings for the switch peripheral.
// Assumes the bus offsets are byte offsets within a 4 KB window.
package sp_pkg;

    localparam int OFF_LEN   = 'h000;
    localparam int OFF_PTR   = 'h004;
    localparam int OFF_FLAGS = 'h008;
    localparam int OFF_STATE = 'h00C;
    localparam int OFF_ISTAT = 'h010;
    localparam int OFF_IEN   = 'h014;

    typedef enum logic [2:0] {
        OP_LEN,
        OP_PTR,
        OP_FLAGS,
        OP_STATE_RD,
        OP_STATE_WR,
        OP_ISTAT,
        OP_IEN,
        OP_BAD
    } sp_op_e;

endpackage

// File: rtl/sp_decode.sv
// Module: sp_decode
// Turns an offset and a direction into one operation code. Every access not
// listed in the map, including a state write on an input-only build, maps to
// OP_BAD. Assumes the offset is already limited to the block's window.
module sp_decode
    import sp_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter bit OUT_CAP = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output sp_op_e            op
);

    // Map offset and direction to an operation.
    always_comb begin
        op = OP_BAD;
        case (addr)
            ADDR_W'(OFF_LEN):   if (!write) op = OP_LEN;
            ADDR_W'(OFF_PTR):   if (write)  op = OP_PTR;
            ADDR_W'(OFF_FLAGS): if (!write) op = OP_FLAGS;
            ADDR_W'(OFF_STATE): op = write ? (OUT_CAP ? OP_STATE_WR : OP_BAD) : OP_STATE_RD;
            ADDR_W'(OFF_ISTAT): if (!write) op = OP_ISTAT;
            ADDR_W'(OFF_IEN):   if (write)  op = OP_IEN;
            default:            op = OP_BAD;
        endcase
    end

endmodule

// File: rtl/sp_name_copy.sv
// Module: sp_name_copy
// Writes the constant name, first character first, to consecutive byte
// addresses from a base address. Each byte is held until the memory accepts
// it. Assumes start is only raised while busy is low and NAME_BYTES >= 1.
module sp_name_copy #(
    parameter int                    NAME_BYTES = 6,
    parameter logic [8*NAME_BYTES-1:0] NAME     = "lid_sw",
    parameter int                    MEM_AW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MEM_AW-1:0] base,
    output logic              busy,
    output logic              mem_wr_valid,
    output logic [MEM_AW-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    input  logic              mem_wr_ready
);

    localparam int IDX_W = (NAME_BYTES > 1) ? $clog2(NAME_BYTES) : 1;

    logic [7:0]        name_rom [NAME_BYTES];
    logic [IDX_W-1:0]  idx_q;
    logic [MEM_AW-1:0] base_q;
    logic              busy_q;

    // Split the name constant into bytes, first character at index 0.
    for (genvar g = 0; g < NAME_BYTES; g++) begin : g_rom
        assign name_rom[g] = NAME[8*(NAME_BYTES-1-g) +: 8];
    end

    // Step through the name one accepted byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            base_q <= base;
        end else if (busy_q && mem_wr_ready) begin
            if (idx_q == IDX_W'(NAME_BYTES-1)) begin
                busy_q <= 1'b0;
            end
            idx_q <= idx_q + 1'b1;
        end
    end

    // Present the current byte and its address.
    always_comb begin
        busy         = busy_q;
        mem_wr_valid = busy_q;
        mem_wr_addr  = base_q + MEM_AW'(idx_q);
        mem_wr_data  = name_rom[idx_q];
    end

endmodule

// File: rtl/sp_out_req.sv
// Module: sp_out_req
// Sends one requested state to the switch side with a valid/ready handshake,
// then waits for the resulting state. done is high in the cycle the result
// arrives. Assumes start is only raised while idle is high.
module sp_out_req #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_data,
    output logic              idle,
    output logic              done,
    output logic              out_req_valid,
    output logic [DATA_W-1:0] out_req_data,
    input  logic              out_req_ready,
    input  logic              out_rsp_valid
);

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} req_st_e;

    req_st_e           st_q;
    logic [DATA_W-1:0] data_q;

    // Move through request, then response wait, then back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            data_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (start) begin
                    st_q   <= S_REQ;
                    data_q <= start_data;
                end
                S_REQ:   if (out_req_ready) st_q <= S_RSP;
                S_RSP:   if (out_rsp_valid) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Drive the handshake outputs from the phase.
    always_comb begin
        idle          = (st_q == S_IDLE);
        done          = (st_q == S_RSP) && out_rsp_valid;
        out_req_valid = (st_q == S_REQ);
        out_req_data  = data_q;
    end

endmodule

// File: rtl/switch_periph.sv
// Module: switch_periph (top)
// Register window for one switch: state, pending-change and enable flags,
// level interrupt, an optional output request path and a name copy engine.
// Assumes the bus master holds a request steady until bus_ready.
module switch_periph
    import sp_pkg::*;
#(
    parameter int                      ADDR_W     = 12,
    parameter int                      DATA_W     = 32,
    parameter int                      MEM_AW     = 32,
    parameter bit                      OUT_CAP    = 1'b1,
    parameter int                      NAME_BYTES = 6,
    parameter logic [8*NAME_BYTES-1:0] NAME       = "lid_sw"
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              err_flag,
    output logic              irq,
    input  logic              sw_upd_valid,
    input  logic [DATA_W-1:0] sw_upd_state,
    output logic              out_req_valid,
    output logic [DATA_W-1:0] out_req_data,
    input  logic              out_req_ready,
    input  logic              out_rsp_valid,
    input  logic [DATA_W-1:0] out_rsp_state,
    output logic              mem_wr_valid,
    output logic [MEM_AW-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    input  logic              mem_wr_ready
);

    sp_op_e            op;
    logic              accept;
    logic              copy_busy;
    logic              copy_start;
    logic              oreq_idle;
    logic              oreq_done;
    logic              oreq_start;
    logic [DATA_W-1:0] state_q, state_n;
    logic              pend_q, pend_n;
    logic              ien_q, ien_n;
    logic              irq_q;
    logic              err_q;

    sp_decode #(.ADDR_W(ADDR_W), .OUT_CAP(OUT_CAP)) u_dec (
        .addr  (bus_addr),
        .write (bus_write),
        .op    (op)
    );

    assign copy_start = accept && (op == OP_PTR);

    sp_name_copy #(.NAME_BYTES(NAME_BYTES), .NAME(NAME), .MEM_AW(MEM_AW)) u_copy (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (copy_start),
        .base         (MEM_AW'(bus_wdata)),
        .busy         (copy_busy),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ready (mem_wr_ready)
    );

    assign oreq_start = bus_req && (op == OP_STATE_WR) && oreq_idle;

    // Output path exists only on the output-capable build.
    if (OUT_CAP) begin : g_out
        sp_out_req #(.DATA_W(DATA_W)) u_oreq (
            .clk           (clk),
            .rst_n         (rst_n),
            .start         (oreq_start),
            .start_data    (bus_wdata),
            .idle          (oreq_idle),
            .done          (oreq_done),
            .out_req_valid (out_req_valid),
            .out_req_data  (out_req_data),
            .out_req_ready (out_req_ready),
            .out_rsp_valid (out_rsp_valid)
        );
    end else begin : g_in
        assign oreq_idle     = 1'b1;
        assign oreq_done     = 1'b0;
        assign out_req_valid = 1'b0;
        assign out_req_data  = '0;
    end

    // Decide when the access completes; copy and output writes may stall.
    always_comb begin
        case (op)
            OP_PTR:      bus_ready = !copy_busy;
            OP_STATE_WR: bus_ready = oreq_done;
            default:     bus_ready = 1'b1;
        endcase
        accept = bus_req && bus_ready;
    end

    // Select read data; invalid and write accesses return 0.
    always_comb begin
        case (op)
            OP_LEN:      bus_rdata = DATA_W'(NAME_BYTES);
            OP_FLAGS:    bus_rdata = DATA_W'(OUT_CAP);
            OP_STATE_RD: bus_rdata = state_q;
            OP_ISTAT:    bus_rdata = DATA_W'(pend_q && ien_q);
            default:     bus_rdata = '0;
        endcase
        bus_err = bus_req && (op == OP_BAD);
    end

    // Next state, pending and enable; a switch-side update has top priority.
    always_comb begin
        state_n = state_q;
        pend_n  = pend_q;
        ien_n   = ien_q;
        if (sw_upd_valid) begin
            state_n = sw_upd_state;
            pend_n  = 1'b1;
        end else if (oreq_done && accept && (out_rsp_state != state_q)) begin
            state_n = out_rsp_state;
            pend_n  = 1'b1;
        end else if (accept && (op == OP_ISTAT) && pend_q && ien_q) begin
            pend_n  = 1'b0;
        end
        if (accept && (op == OP_IEN)) begin
            ien_n = bus_wdata[0];
        end
    end

    // Register the flags, the interrupt level and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            pend_q  <= 1'b0;
            ien_q   <= 1'b0;
            irq_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
            ien_q   <= ien_n;
            irq_q   <= pend_n && ien_n;
            if (accept && (op == OP_BAD)) err_q <= 1'b1;
        end
    end

    assign irq      = irq_q;
    assign err_flag = err_q;

endmodule

// File: rtl/sp_chk.sv
// Module: sp_chk
// Assertions for switch_periph, attached by bind below.
// Assumes a bus master that holds its request steady until bus_ready.
module sp_chk #(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ready,
    input logic              bus_err,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              err_flag,
    input logic              irq,
    input logic              sw_upd_valid,
    input logic [DATA_W-1:0] sw_upd_state,
    input logic              out_req_valid,
    input logic              out_req_ready,
    input logic [DATA_W-1:0] out_req_data,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [MEM_AW-1:0] mem_wr_addr,
    input logic [7:0]        mem_wr_data,
    input logic [DATA_W-1:0] state,
    input logic              pend,
    input logic              ien
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (state == '0) && !pend && !ien && !irq && !err_flag);

    a_r4_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=>
            mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

    a_r5_update_stored: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd_valid |=> pend && (state == $past(sw_upd_state)));

    a_r5_irq_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd_valid && ien |=> irq);

    a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> !irq);

    a_r8_stall_while_requesting: assert property (@(posedge clk) disable iff (!rst_n)
        out_req_valid && bus_req |-> !bus_ready);

    a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        out_req_valid && !out_req_ready |=> out_req_valid && $stable(out_req_data));

    a_r9_error_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ready && (bus_rdata == '0));

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    a_r9_error_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> err_flag);

endmodule

bind switch_periph sp_chk #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_ready     (bus_ready),
    .bus_err       (bus_err),
    .bus_rdata     (bus_rdata),
    .err_flag      (err_flag),
    .irq           (irq),
    .sw_upd_valid  (sw_upd_valid),
    .sw_upd_state  (sw_upd_state),
    .out_req_valid (out_req_valid),
    .out_req_ready (out_req_ready),
    .out_req_data  (out_req_data),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_ready  (mem_wr_ready),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .state         (state_q),
    .pend          (pend_q),
    .ien           (ien_q)
);

// File: tb/tb_switch_periph.sv
// Directed bench: one task per scenario. dut is output-capable, dut_ro is
// input-only. Inputs change at the falling edge; outputs are sampled 1-2 ns
// after an edge.
module tb_switch_periph;

    localparam int CLK_HALF = 10; // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_write = 1'b0, sel_ro = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        req_a, req_b;
    logic        ready_a, ready_b, err_a, err_b, eflag_a, eflag_b, irq_a, irq_b;
    logic [31:0] rdata_a, rdata_b;
    logic        sw_upd_valid = 1'b0;
    logic [31:0] sw_upd_state = '0;
    logic        out_req_valid, out_req_ready = 1'b0, out_rsp_valid = 1'b0;
    logic [31:0] out_req_data, out_rsp_state = '0;
    logic        mem_wr_valid, mem_wr_ready = 1'b0;
    logic [31:0] mem_wr_addr;
    logic [7:0]  mem_wr_data;
    logic        ro_oreq_valid, ro_mem_valid;
    logic [31:0] ro_oreq_data, ro_mem_addr;
    logic [7:0]  ro_mem_data;

    int checks = 0, failures = 0;
    logic [31:0] rsp_xor = '0, captured = '0;
    int          phase = 0;
    logic [31:0] log_addr [8];
    logic [7:0]  log_data [8];
    int          log_n = 0;
    logic [47:0] exp_name = "lid_sw";

    always #(CLK_HALF) clk = ~clk;

    assign req_a = bus_req && !sel_ro;
    assign req_b = bus_req && sel_ro;

    switch_periph dut (
        .clk(clk), .rst_n(rst_n), .bus_req(req_a), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(ready_a),
        .bus_rdata(rdata_a), .bus_err(err_a), .err_flag(eflag_a), .irq(irq_a),
        .sw_upd_valid(sw_upd_valid), .sw_upd_state(sw_upd_state),
        .out_req_valid(out_req_valid), .out_req_data(out_req_data),
        .out_req_ready(out_req_ready), .out_rsp_valid(out_rsp_valid),
        .out_rsp_state(out_rsp_state), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(mem_wr_ready)
    );

    switch_periph #(.OUT_CAP(1'b0)) dut_ro (
        .clk(clk), .rst_n(rst_n), .bus_req(req_b), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(ready_b),
        .bus_rdata(rdata_b), .bus_err(err_b), .err_flag(eflag_b), .irq(irq_b),
        .sw_upd_valid(1'b0), .sw_upd_state(32'h0),
        .out_req_valid(ro_oreq_valid), .out_req_data(ro_oreq_data),
        .out_req_ready(1'b0), .out_rsp_valid(1'b0), .out_rsp_state(32'h0),
        .mem_wr_valid(ro_mem_valid), .mem_wr_addr(ro_mem_addr),
        .mem_wr_data(ro_mem_data), .mem_wr_ready(1'b1)
    );

    // Switch-side model: accept the request, answer two cycles later.
    always @(negedge clk) begin
        case (phase)
            0: if (out_req_valid) begin
                   out_req_ready = 1'b1;
                   captured      = out_req_data;
                   phase         = 1;
               end
            1: begin out_req_ready = 1'b0; phase = 2; end
            2: phase = 3;
            3: begin
                   out_rsp_valid = 1'b1;
                   out_rsp_state = captured ^ rsp_xor;
                   phase         = 4;
               end
            default: begin out_rsp_valid = 1'b0; phase = 0; end
        endcase
    end

    // Memory model: ready every other cycle; log each accepted byte.
    always @(negedge clk) begin
        mem_wr_ready = ~mem_wr_ready;
        #2;
        if (mem_wr_valid && mem_wr_ready && log_n < 8) begin
            log_addr[log_n] = mem_wr_addr;
            log_data[log_n] = mem_wr_data;
            log_n++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input bit ro, input bit wr, input logic [11:0] addr,
                       input logic [31:0] wdata, output logic [31:0] rdata,
                       output logic err, output int waits);
        waits = 0;
        @(negedge clk);
        sel_ro = ro; bus_write = wr; bus_addr = addr; bus_wdata = wdata; bus_req = 1'b1;
        forever begin
            #2;
            if (ro ? ready_b : ready_a) break;
            waits++;
            @(negedge clk);
        end
        rdata = ro ? rdata_b : rdata_a;
        err   = ro ? err_b : err_a;
        @(posedge clk);
        #1 bus_req = 1'b0;
    endtask

    task automatic sw_update(input logic [31:0] v);
        @(negedge clk);
        sw_upd_valid = 1'b1; sw_upd_state = v;
        @(posedge clk);
        #1 sw_upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e; int w;
        check(!irq_a && !eflag_a, "R1 irq/err after reset", {irq_a, eflag_a}, 0);
        bus(0, 0, 12'h00C, 0, d, e, w); check(d == 0, "R1 state after reset", d, 0);
        bus(0, 0, 12'h010, 0, d, e, w); check(d == 0, "R1 status after reset", d, 0);
        bus(0, 0, 12'h000, 0, d, e, w); check(d == 6 && !e, "R2 name length", d, 6);
        bus(0, 0, 12'h008, 0, d, e, w); check(d == 1, "R3 flags output-capable", d, 1);
        bus(1, 0, 12'h008, 0, d, e, w); check(d == 0, "R3 flags input-only", d, 0);
    endtask

    task automatic t_pending_disabled();
        logic [31:0] d; logic e; int w;
        sw_update(32'h5);
        #1 check(!irq_a, "R5 no irq while disabled", irq_a, 0);
        bus(0, 0, 12'h010, 0, d, e, w); check(d == 0, "R6 status read disabled", d, 0);
        bus(0, 1, 12'h014, 32'h1, d, e, w);
        #1 check(irq_a, "R7 enable raises irq, pending kept", irq_a, 1);
        bus(0, 0, 12'h00C, 0, d, e, w); check(d == 32'h5, "R5 state stored", d, 5);
        bus(0, 0, 12'h010, 0, d, e, w); check(d == 1, "R6 status read returns 1", d, 1);
        #1 check(!irq_a, "R6 read clears irq", irq_a, 0);
        bus(0, 0, 12'h010, 0, d, e, w); check(d == 0, "R6 second read returns 0", d, 0);
    endtask

    task automatic t_enable_mask();
        logic [31:0] d; logic e; int w;
        sw_update(32'h9);
        #1 check(irq_a, "R5 irq when enabled", irq_a, 1);
        bus(0, 1, 12'h014, 32'h2, d, e, w);
        #1 check(!irq_a, "R7 only bit 0 kept", irq_a, 0);
        bus(0, 1, 12'h014, 32'h3, d, e, w);
        #1 check(irq_a, "R7 irq follows enable", irq_a, 1);
        bus(0, 0, 12'h010, 0, d, e, w); check(d == 1, "R6 clear after re-enable", d, 1);
    endtask

    task automatic t_output_write();
        logic [31:0] d; logic e; int w;
        rsp_xor = 0;
        bus(0, 1, 12'h00C, 32'hA5, d, e, w);
        check(w >= 2 && !e, "R8 bus stalls for response", w, 2);
        check(captured == 32'hA5, "R8 value forwarded", captured, 32'hA5);
        #1 check(irq_a, "R8 changed result flags change", irq_a, 1);
        bus(0, 0, 12'h010, 0, d, e, w); check(d == 1, "R8 change pending", d, 1);
        bus(0, 1, 12'h00C, 32'hA5, d, e, w);
        #1 check(!irq_a, "R8 equal result no irq", irq_a, 0);
        bus(0, 0, 12'h010, 0, d, e, w); check(d == 0, "R8 equal result not pending", d, 0);
        rsp_xor = 32'hF0;
        bus(0, 1, 12'h00C, 32'h0F, d, e, w);
        bus(0, 0, 12'h00C, 0, d, e, w); check(d == 32'hFF, "R8 result state stored", d, 32'hFF);
        bus(0, 0, 12'h010, 0, d, e, w);
    endtask

    task automatic t_name_copy();
        logic [31:0] d; logic e; int w;
        bus(0, 1, 12'h004, 32'h100, d, e, w);
        for (int i = 0; i < 100 && log_n < 6; i++) @(negedge clk);
        check(log_n == 6, "R4 byte count", log_n, 6);
        for (int i = 0; i < 6; i++) begin
            check(log_addr[i] == 32'h100 + i, "R4 byte address", log_addr[i], 32'h100 + i);
            check(log_data[i] == exp_name[8*(5-i) +: 8], "R4 byte value",
                  log_data[i], exp_name[8*(5-i) +: 8]);
        end
    endtask

    task automatic t_race();
        logic [31:0] d; logic e; int w;
        sw_update(32'h11);
        @(negedge clk);
        sel_ro = 0; bus_write = 0; bus_addr = 12'h010; bus_req = 1'b1;
        sw_upd_valid = 1'b1; sw_upd_state = 32'h77;
        #2 d = rdata_a;
        @(posedge clk);
        #1 bus_req = 1'b0; sw_upd_valid = 1'b0;
        check(d == 1, "R10 racing read data", d, 1);
        check(irq_a, "R10 update wins, irq held", irq_a, 1);
        bus(0, 0, 12'h00C, 0, d, e, w); check(d == 32'h77, "R10 new state", d, 32'h77);
        bus(0, 0, 12'h010, 0, d, e, w); check(d == 1, "R10 still pending", d, 1);
    endtask

    task automatic t_errors();
        logic [31:0] d; logic e; int w;
        bus(1, 1, 12'h00C, 32'h3, d, e, w);
        check(e && d == 0, "R9 state write on input-only", e, 1);
        #1 check(eflag_b, "R9 sticky flag input-only", eflag_b, 1);
        bus(1, 0, 12'h00C, 0, d, e, w); check(d == 0, "R9 input-only state unchanged", d, 0);
        check(!eflag_a, "R9 no flag before error", eflag_a, 0);
        bus(0, 0, 12'h018, 0, d, e, w); check(e && d == 0, "R9 unmapped read", d, 0);
        bus(0, 1, 12'h000, 32'h1, d, e, w); check(e, "R9 write to read-only", e, 1);
        bus(0, 0, 12'h014, 0, d, e, w); check(e && d == 0, "R9 read of write-only", d, 0);
        bus(0, 0, 12'h00E, 0, d, e, w); check(e, "R9 misaligned offset", e, 1);
        bus(0, 0, 12'h000, 0, d, e, w);
        check(!e && eflag_a, "R9 flag stays after good access", eflag_a, 1);
    endtask

    initial begin
        #(2 * CLK_HALF * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        t_reset();
        t_pending_disabled();
        t_enable_mask();
        t_output_write();
        t_name_copy();
        t_race();
        t_errors();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule